// File: doc/BRIEF.md
# Serial Escape Sequence Detector

This block sits beside a serial receiver and watches the stream of received bytes for a modem-style escape: a short burst of one repeated command character, with quiet line time before the burst and after it. It measures idle time in baud ticks. The idle count restarts on every received byte and only grows while the baud tick is high. The block raises a one-cycle detection pulse only when the whole timing pattern holds. That pulse also sets a sticky interrupt flag, which software clears by writing 1.

The command character, the number of characters in the burst, and the three idle windows come in on configuration inputs. The windows are: quiet time before the first character, the longest gap allowed between characters, and quiet time after the last character. Receiving bytes and storing them are handled elsewhere. The block only sees a byte strobe with its data.

Top module: `esc_seq_detector`

## Requirements
- R1: After reset, `detect_pulse` and `irq_flag` are 0, and the idle count starts from 0.
- R2: A run of exactly `cfg_run_len` command characters that meets every timing rule makes `detect_pulse` go high for exactly one cycle. With the baud tick held high, this happens on the (`cfg_post_idle`+1)-th clock edge after the edge that took the last character.
- R3: The first character counts only if the idle count when it arrives is at least `cfg_pre_idle`. The boundary value equal to the limit is accepted.
- R4: Each following character must arrive with an idle count no greater than `cfg_gap_limit`. The boundary value is accepted. A larger gap breaks the run.
- R5: Any byte that arrives while the post-idle window is counting cancels the run, so there is no detection.
- R6: A command character beyond the configured run length cancels the run.
- R7: A byte that is not the command character cancels a run in progress. The next run then needs a fresh pre-idle period.
- R8: The idle count advances only on clock edges where `baud_tick` is 1. It restarts at 0 on a received byte, and it saturates at its all-ones maximum instead of wrapping.
- R9: `irq_flag` is set in the same cycle as `detect_pulse` and stays set until `irq_clear` is 1 at a clock edge. If a detection and a clear fall on the same edge, the flag stays set.
- R10: A run length of 0 disables detection.
- R11: The command character and the run length are taken from `cfg_cmd_char` and `cfg_run_len`. A different character with a run length of 1 is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One baud period has elapsed |
| rx_valid | input | 1 | Received-byte strobe, one cycle per byte |
| rx_data | input | 8 | Received byte |
| cfg_cmd_char | input | 8 | Command character value |
| cfg_run_len | input | 8 | Number of command characters in the burst |
| cfg_pre_idle | input | 16 | Minimum idle ticks before the first character |
| cfg_gap_limit | input | 16 | Maximum idle ticks between characters |
| cfg_post_idle | input | 16 | Idle ticks after the last character before detection |
| irq_clear | input | 1 | Write-1 clear of the sticky flag |
| detect_pulse | output | 1 | One-cycle detection event |
| irq_flag | output | 1 | Sticky detection flag |

## Verification
With the baud tick held high, the detection pulse is due on the (post-idle + 1)-th edge after the edge that took the last character. The sticky flag rises on that same edge, and a clear takes effect on the next edge. The driver records the edge that takes each strobed byte and queues the edge on which a detection is due. The monitor samples on falling clock edges and compares every pulse it sees against the head of that queue, so an early, late, missing or extra pulse is each reported. Idle-count values at byte arrival are set exactly by the number of quiet cycles the driver inserts, which lets the boundary cases land on the limit values.

// File: rtl/esc_seq_pkg.sv
package esc_seq_pkg;

  typedef enum logic [2:0] {
    ACT_KEEP,
    ACT_START,
    ACT_ADVANCE,
    ACT_DROP,
    ACT_FIRE
  } esc_act_e;

  // Decision for one cycle, from single-bit conditions only.
  function automatic esc_act_e esc_decide(
    input logic byte_in,
    input logic is_cmd,
    input logic len_zero,
    input logic armed,
    input logic full,
    input logic pre_ok,
    input logic gap_ok,
    input logic post_ok
  );
    esc_act_e a;
    a = ACT_KEEP;
    if (len_zero) begin
      a = armed ? ACT_DROP : ACT_KEEP;
    end else if (byte_in) begin
      if (!is_cmd)      a = ACT_DROP;
      else if (!armed)  a = pre_ok ? ACT_START : ACT_DROP;
      else if (full)    a = ACT_DROP;
      else              a = gap_ok ? ACT_ADVANCE : ACT_DROP;
    end else if (armed && full) begin
      a = post_ok ? ACT_FIRE : ACT_KEEP;
    end else if (armed && !gap_ok) begin
      a = ACT_DROP;
    end
    return a;
  endfunction

endpackage

// File: rtl/esc_idle_timer.sv
module esc_idle_timer #(
  parameter int unsigned IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              restart,
  output logic [IDLE_W-1:0] idle
);
  localparam logic [IDLE_W-1:0] IDLE_MAX = {IDLE_W{1'b1}};

  function automatic logic [IDLE_W-1:0] idle_step(
    input logic [IDLE_W-1:0] cur,
    input logic              t,
    input logic              r
  );
    if (r)                          return '0;
    else if (t && cur != IDLE_MAX)  return cur + 1'b1;
    else                            return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idle <= '0;
    else        idle <= idle_step(idle, tick, restart);
  end
endmodule

// File: rtl/esc_seq_tracker.sv
module esc_seq_tracker
  import esc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RUN_W  = 8,
  parameter int unsigned IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W-1:0] cmd_char,
  input  logic [RUN_W-1:0]  run_len,
  input  logic [IDLE_W-1:0] pre_idle,
  input  logic [IDLE_W-1:0] gap_limit,
  input  logic [IDLE_W-1:0] post_idle,
  input  logic [IDLE_W-1:0] idle,
  output logic              fire
);
  logic [RUN_W-1:0] seen_n;
  esc_act_e         act;
  logic             armed, full;

  assign armed = (seen_n != '0);
  assign full  = (seen_n >= run_len);

  always_comb begin
    act = esc_decide(rx_valid, rx_data == cmd_char, run_len == '0,
                     armed, full, idle >= pre_idle, idle <= gap_limit,
                     idle >= post_idle);
  end

  assign fire = (act == ACT_FIRE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_n <= '0;
    end else begin
      unique case (act)
        ACT_START:   seen_n <= RUN_W'(1);
        ACT_ADVANCE: seen_n <= seen_n + 1'b1;
        ACT_DROP,
        ACT_FIRE:    seen_n <= '0;
        default:     seen_n <= seen_n;
      endcase
    end
  end
endmodule

// File: rtl/esc_irq_latch.sv
module esc_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clear,
  output logic pulse,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      flag  <= 1'b0;
    end else begin
      pulse <= set_evt;
      flag  <= set_evt | (flag & ~clear);
    end
  end
endmodule

// File: rtl/esc_seq_detector.sv
module esc_seq_detector #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RUN_W  = 8,
  parameter int unsigned IDLE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [DATA_W-1:0] cfg_cmd_char,
  input  logic [RUN_W-1:0]  cfg_run_len,
  input  logic [IDLE_W-1:0] cfg_pre_idle,
  input  logic [IDLE_W-1:0] cfg_gap_limit,
  input  logic [IDLE_W-1:0] cfg_post_idle,
  input  logic              irq_clear,
  output logic              detect_pulse,
  output logic              irq_flag
);
  logic [IDLE_W-1:0] idle_cnt;
  logic              fire_evt;

  esc_idle_timer #(.IDLE_W(IDLE_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (baud_tick),
    .restart (rx_valid),
    .idle    (idle_cnt)
  );

  esc_seq_tracker #(.DATA_W(DATA_W), .RUN_W(RUN_W), .IDLE_W(IDLE_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_data   (rx_data),
    .cmd_char  (cfg_cmd_char),
    .run_len   (cfg_run_len),
    .pre_idle  (cfg_pre_idle),
    .gap_limit (cfg_gap_limit),
    .post_idle (cfg_post_idle),
    .idle      (idle_cnt),
    .fire      (fire_evt)
  );

  esc_irq_latch u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (fire_evt),
    .clear   (irq_clear),
    .pulse   (detect_pulse),
    .flag    (irq_flag)
  );
endmodule

// File: rtl/esc_seq_checker.sv
module esc_seq_checker #(
  parameter int unsigned RUN_W  = 8,
  parameter int unsigned IDLE_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              baud_tick,
  input logic              rx_valid,
  input logic              irq_clear,
  input logic [RUN_W-1:0]  cfg_run_len,
  input logic [IDLE_W-1:0] idle_cnt,
  input logic              detect_pulse,
  input logic              irq_flag
);
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    detect_pulse |=> !detect_pulse);

  p_quiet_before_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(detect_pulse) |-> !$past(rx_valid));

  p_idle_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> idle_cnt == '0);

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_valid && !baud_tick) |=> $stable(idle_cnt));

  p_flag_with_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    detect_pulse |-> irq_flag);

  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clear) |=> irq_flag);

  p_zero_len_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_run_len == '0 && $past(cfg_run_len) == '0) |=> !detect_pulse);
endmodule

bind esc_seq_detector esc_seq_checker #(.RUN_W(RUN_W), .IDLE_W(IDLE_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .baud_tick    (baud_tick),
  .rx_valid     (rx_valid),
  .irq_clear    (irq_clear),
  .cfg_run_len  (cfg_run_len),
  .idle_cnt     (idle_cnt),
  .detect_pulse (detect_pulse),
  .irq_flag     (irq_flag)
);

// File: tb/esc_seq_detector_tb.sv
module esc_seq_detector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        baud_tick = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = 8'h00;
  logic [7:0]  cfg_cmd_char = 8'h2B;
  logic [7:0]  cfg_run_len = 8'd3;
  logic [15:0] cfg_pre_idle = 16'd20;
  logic [15:0] cfg_gap_limit = 16'd5;
  logic [15:0] cfg_post_idle = 16'd20;
  logic        irq_clear = 1'b0;
  logic        detect_pulse, irq_flag;

  int checks = 0;
  int errors = 0;
  int edge_n = 0;
  int last_edge = 0;
  int exp_q[$];
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  esc_seq_detector dut_i (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .rx_valid(rx_valid),
    .rx_data(rx_data), .cfg_cmd_char(cfg_cmd_char), .cfg_run_len(cfg_run_len),
    .cfg_pre_idle(cfg_pre_idle), .cfg_gap_limit(cfg_gap_limit),
    .cfg_post_idle(cfg_post_idle), .irq_clear(irq_clear),
    .detect_pulse(detect_pulse), .irq_flag(irq_flag)
  );

  always @(posedge clk) edge_n <= edge_n + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor: every pulse must match the head of the expected queue.
  always @(negedge clk) begin
    if (rst_n && detect_pulse && !done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected detection at edge", edge_n, -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(edge_n == e, "R2 detection edge", edge_n, e);
      end
    end
  end

  // Driver: wait quiet cycles, then strobe one byte.
  task automatic send(input logic [7:0] d, input int quiet);
    repeat (quiet) @(negedge clk);
    rx_data = d;
    rx_valid = 1'b1;
    last_edge = edge_n + 1;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic expect_det();
    exp_q.push_back(last_edge + int'(cfg_post_idle) + 1);
  endtask

  task automatic settle(input string req);
    repeat (int'(cfg_post_idle) + 10) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic clear_irq();
    irq_clear = 1'b1;
    @(negedge clk);
    irq_clear = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0", edge_n);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(detect_pulse == 1'b0, "R1 pulse after reset", detect_pulse, 0);
    check(irq_flag == 1'b0, "R1 flag after reset", irq_flag, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R4 boundary gap (== limit) accepted
    send(8'h2B, 25); send(8'h2B, 3); send(8'h2B, 5); expect_det();
    settle("R2 basic detection missing");
    check(irq_flag == 1'b1, "R9 flag set", irq_flag, 1);
    clear_irq();
    check(irq_flag == 1'b0, "R9 flag cleared", irq_flag, 0);

    // R3 short pre-idle rejected
    send(8'h00, 30); send(8'h2B, 19); send(8'h2B, 2); send(8'h2B, 2);
    settle("R3 short pre-idle");
    // R3 boundary pre-idle == limit accepted
    send(8'h00, 0); send(8'h2B, 20); send(8'h2B, 1); send(8'h2B, 1); expect_det();
    settle("R3 boundary pre-idle missing");

    // R4 gap one over limit breaks
    send(8'h00, 0); send(8'h2B, 30); send(8'h2B, 6); send(8'h2B, 1);
    settle("R4 long gap");

    // R5 other byte during post window
    send(8'h2B, 30); send(8'h2B, 1); send(8'h2B, 1); send(8'h41, 10);
    settle("R5 byte in post window");

    // R6 extra command character
    send(8'h2B, 30); send(8'h2B, 1); send(8'h2B, 1); send(8'h2B, 1);
    settle("R6 extra character");

    // R7 non-command byte mid-run
    send(8'h2B, 30); send(8'h41, 1); send(8'h2B, 1); send(8'h2B, 1);
    settle("R7 foreign byte");

    // R11 other character, run length 1
    cfg_cmd_char = 8'h41; cfg_run_len = 8'd1;
    send(8'h41, 30); expect_det();
    settle("R11 custom char missing");
    cfg_cmd_char = 8'h2B;

    // R10 run length 0
    cfg_run_len = 8'd0;
    send(8'h2B, 30);
    settle("R10 zero length");
    cfg_run_len = 8'd3;

    // R8 no baud ticks: idle stays low, first char rejected
    baud_tick = 1'b0;
    send(8'h00, 0); send(8'h2B, 50);
    baud_tick = 1'b1;
    send(8'h2B, 1); send(8'h2B, 1);
    settle("R8 idle grew without tick");

    // R8 saturation: 70000 quiet ticks still meet an all-ones pre-idle
    cfg_pre_idle = 16'hFFFF;
    send(8'h00, 0); send(8'h2B, 70000); send(8'h2B, 1); send(8'h2B, 1); expect_det();
    settle("R8 saturation detection missing");
    cfg_pre_idle = 16'd20;
    clear_irq();

    // R9 set wins over same-edge clear
    send(8'h2B, 30); send(8'h2B, 1); send(8'h2B, 1); expect_det();
    while (edge_n != last_edge + int'(cfg_post_idle)) @(negedge clk);
    irq_clear = 1'b1;
    @(negedge clk);
    irq_clear = 1'b0;
    check(irq_flag == 1'b1, "R9 set wins over clear", irq_flag, 1);
    settle("R9 detection missing");
    clear_irq();
    check(irq_flag == 1'b0, "R9 flag cleared again", irq_flag, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule